// File: doc/BRIEF.md
# Performance Counter Bank with Overflow Status and Indexed Read

This block holds a bank of general-purpose event counters and a bank of fixed-function event counters. It also holds the shared controls that decide when each counter runs and what happens when one wraps. The general-purpose counters count pre-filtered event strobes that arrive on inputs, and each is gated by one bit of a 64-bit global enable word. Each fixed counter counts its own dedicated event input. It is gated by its global enable bit and by a 4-bit field in a packed control word, and that field selects the privilege modes to count in and whether an overflow should interrupt.

A counter that wraps from all ones to zero sets a sticky bit in a 64-bit overflow status word. General-purpose counter i owns bit i and fixed counter i owns bit 32+i, the same layout the enable word uses. Software clears status bits by writing a mask. A single interrupt line is raised while any status bit is set whose counter has its interrupt enabled.

A combinational read port takes a 32-bit index. The index selects the bank and the counter, and it chooses between a full-width read and a narrow 32-bit read.

Top module: `pmon_unit`

## Requirements
- R1: After reset every counter reads zero, the overflow status word and the global enable word are zero, and the interrupt output is low.
- R2: A write to a counter (wr_kind 0 for general-purpose, 1 for fixed, wr_idx selects the counter) uses only wr_data[31:0]. That value is sign-extended from bit 31 to the counter width and the upper 32 bits of wr_data are ignored.
- R3: General-purpose counter i adds one on each clock where its event input is high and global enable bit i is set; it holds otherwise. The global enable word is written with wr_kind 3.
- R4: Fixed counter i adds one on each clock where its event input is high, global enable bit 32+i is set, and its control field permits the current mode. The field sits at bits 4i+3..4i of the word written with wr_kind 2. Bit 4i permits kernel mode (user_mode low) and bit 4i+1 permits user mode (user_mode high). A field with neither bit set stops the counter.
- R5: When a counter steps from all ones to zero, its status bit is set on that same clock edge. General-purpose counter i uses bit i and fixed counter i uses bit 32+i.
- R6: A write with wr_kind 4 clears every status bit whose wr_data bit is 1 and leaves the other bits unchanged.
- R7: If a counter overflows on the same clock as a clear write that covers its status bit, the bit stays set.
- R8: irq is high while some status bit is set whose interrupt enable is set. For general-purpose counter i that enable is the gp_int_en[i] input, and for fixed counter i it is control-word bit 4i+3. irq stays high until the bit is cleared.
- R9: rd_idx bit 30 selects the fixed bank (1) or the general-purpose bank (0), and rd_idx[29:0] selects the counter. With rd_idx bit 31 low, rd_data is the counter's full value zero-extended to 64 bits.
- R10: With rd_idx bit 31 high, rd_data is the counter's low 32 bits zero-extended to 64 bits.
- R11: An index that names a counter that does not exist in the selected bank gives rd_data of zero and rd_err high. A valid index gives rd_err low.
- R12: A software write to a counter takes priority over an event on the same clock. The counter holds the written value and the event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Write target: 0 GP counter, 1 fixed counter, 2 fixed control, 3 global enable, 4 overflow clear |
| wr_idx | input | 5 | Counter number for counter writes |
| wr_data | input | 64 | Write data |
| gp_evt | input | NUM_GP | Per-cycle event strobes of the general-purpose counters |
| gp_int_en | input | NUM_GP | Interrupt-on-overflow enables of the general-purpose counters |
| fx_evt | input | NUM_FX | Per-cycle event strobes of the fixed counters |
| user_mode | input | 1 | Current privilege mode, 1 = user, 0 = kernel |
| rd_idx | input | 32 | Read index: bit 31 narrow read, bit 30 fixed bank, low bits counter |
| rd_data | output | 64 | Read result |
| rd_err | output | 1 | Read index names no counter |
| gbl_enable | output | 64 | Global enable word |
| ovf_status | output | 64 | Overflow status word |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that wr_kind carries one of the five defined codes whenever wr_en is high. They also assume wr_idx stays below the bank size on counter writes and that rd_idx is held steady while it is sampled. The bench keeps to these limits, drives every input on the falling clock edge and reads the results half a cycle later. It loads counters near the wrap point by writing 0xFFFFFFFF, which the sign extension turns into all ones. That lets each overflow, and each overflow that coincides with a clear, be produced with a single event strobe. These single-strobe runs are needed because the interrupt property relies on the interrupt enables staying constant across the cycle in which an overflow lands.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

  typedef enum logic [2:0] {
    WK_GP_CTR  = 3'd0,
    WK_FX_CTR  = 3'd1,
    WK_FX_CTL  = 3'd2,
    WK_GBL_EN  = 3'd3,
    WK_OVF_CLR = 3'd4
  } wr_kind_e;

  localparam int FX_BIT_BASE = 32;
  localparam int FLD_W       = 4;
  localparam int FLD_KERN    = 0;
  localparam int FLD_USER    = 1;
  localparam int FLD_PMI     = 3;

  // Bits of the enable/status words that belong to an existing counter.
  function automatic logic [63:0] impl_mask(int ngp, int nfx);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < ngp; i++) m[i] = 1'b1;
    for (int i = 0; i < nfx; i++) m[FX_BIT_BASE + i] = 1'b1;
    return m;
  endfunction

  // Whether a fixed counter may count in the current privilege mode.
  function automatic logic mode_permits(logic kern_ok, logic user_ok, logic user);
    return user ? user_ok : kern_ok;
  endfunction

  // Narrow read view: low 32 bits, zero-extended.
  function automatic logic [63:0] narrow_view(logic [63:0] v);
    return {32'd0, v[31:0]};
  endfunction

endpackage

// File: rtl/pmon_ctr.sv
module pmon_ctr #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [31:0]  ld_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         ovf
);
  localparam int EXT = W - 32;

  logic [W-1:0] ld_ext;

  generate
    if (W > 32) begin : g_wide
      assign ld_ext = {{EXT{ld_val[31]}}, ld_val};
    end else begin : g_narrow
      assign ld_ext = ld_val[W-1:0];
    end
  endgenerate

  // A load wins over an event, so no wrap is reported under a load.
  assign ovf = inc & ~ld & (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (ld)  value <= ld_ext;
    else if (inc) value <= value + 1'b1;
  end
endmodule

// File: rtl/pmon_ovf_stat.sv
module pmon_ovf_stat (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] set_vec,
  input  logic [63:0] clr_vec,
  input  logic [63:0] int_mask,
  output logic [63:0] status,
  output logic        irq
);
  // Set has priority over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end

  assign irq = |(status & int_mask);
endmodule

// File: rtl/pmon_rdmux.sv
module pmon_rdmux #(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 48,
  parameter int FX_W   = 48
) (
  input  logic [NUM_GP*GP_W-1:0] gp_vals,
  input  logic [NUM_FX*FX_W-1:0] fx_vals,
  input  logic [31:0]            rd_idx,
  output logic [63:0]            rd_data,
  output logic                   rd_err
);
  import pmon_pkg::*;

  logic [29:0] sel;
  logic [63:0] full;
  logic        hit;

  assign sel = rd_idx[29:0];

  always_comb begin
    full = '0;
    hit  = 1'b0;
    if (!rd_idx[30]) begin
      for (int i = 0; i < NUM_GP; i++) begin
        if (sel == 30'(i)) begin
          hit  = 1'b1;
          full = 64'(gp_vals[i*GP_W +: GP_W]);
        end
      end
    end else begin
      for (int i = 0; i < NUM_FX; i++) begin
        if (sel == 30'(i)) begin
          hit  = 1'b1;
          full = 64'(fx_vals[i*FX_W +: FX_W]);
        end
      end
    end
  end

  assign rd_err  = ~hit;
  assign rd_data = !hit ? 64'd0 : (rd_idx[31] ? narrow_view(full) : full);
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit #(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 48,
  parameter int FX_W   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [4:0]        wr_idx,
  input  logic [63:0]       wr_data,
  input  logic [NUM_GP-1:0] gp_evt,
  input  logic [NUM_GP-1:0] gp_int_en,
  input  logic [NUM_FX-1:0] fx_evt,
  input  logic              user_mode,
  input  logic [31:0]       rd_idx,
  output logic [63:0]       rd_data,
  output logic              rd_err,
  output logic [63:0]       gbl_enable,
  output logic [63:0]       ovf_status,
  output logic              irq
);
  import pmon_pkg::*;

  localparam logic [63:0] IMPL = impl_mask(NUM_GP, NUM_FX);

  wr_kind_e kind;
  assign kind = wr_kind_e'(wr_kind);

  logic [63:0]       gbl_q;
  logic [NUM_FX-1:0] fx_kern_q, fx_user_q, fx_pmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gbl_q     <= '0;
      fx_kern_q <= '0;
      fx_user_q <= '0;
      fx_pmi_q  <= '0;
    end else if (wr_en) begin
      if (kind == WK_GBL_EN) gbl_q <= wr_data & IMPL;
      if (kind == WK_FX_CTL) begin
        for (int i = 0; i < NUM_FX; i++) begin
          fx_kern_q[i] <= wr_data[FLD_W*i + FLD_KERN];
          fx_user_q[i] <= wr_data[FLD_W*i + FLD_USER];
          fx_pmi_q[i]  <= wr_data[FLD_W*i + FLD_PMI];
        end
      end
    end
  end

  assign gbl_enable = gbl_q;

  // Named internal events, observed by the checker.
  logic [63:0]       ovf_vec, clr_vec, int_mask;
  logic [NUM_GP-1:0] gp_ovf;
  logic [NUM_FX-1:0] fx_ovf;
  logic [NUM_GP*GP_W-1:0] gp_vals;
  logic [NUM_FX*FX_W-1:0] fx_vals;

  assign clr_vec = (wr_en && kind == WK_OVF_CLR) ? (wr_data & IMPL) : 64'd0;

  genvar g;
  generate
    for (g = 0; g < NUM_GP; g++) begin : g_gp
      logic [GP_W-1:0] val;
      pmon_ctr #(.W(GP_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (wr_en && kind == WK_GP_CTR && wr_idx == 5'(g)),
        .ld_val (wr_data[31:0]),
        .inc    (gp_evt[g] & gbl_q[g]),
        .value  (val),
        .ovf    (gp_ovf[g])
      );
      assign gp_vals[g*GP_W +: GP_W] = val;
    end
    for (g = 0; g < NUM_FX; g++) begin : g_fx
      logic [FX_W-1:0] val;
      pmon_ctr #(.W(FX_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (wr_en && kind == WK_FX_CTR && wr_idx == 5'(g)),
        .ld_val (wr_data[31:0]),
        .inc    (fx_evt[g] & gbl_q[FX_BIT_BASE + g] &
                 mode_permits(fx_kern_q[g], fx_user_q[g], user_mode)),
        .value  (val),
        .ovf    (fx_ovf[g])
      );
      assign fx_vals[g*FX_W +: FX_W] = val;
    end
  endgenerate

  always_comb begin
    ovf_vec  = '0;
    int_mask = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      ovf_vec[i]  = gp_ovf[i];
      int_mask[i] = gp_int_en[i];
    end
    for (int i = 0; i < NUM_FX; i++) begin
      ovf_vec[FX_BIT_BASE + i]  = fx_ovf[i];
      int_mask[FX_BIT_BASE + i] = fx_pmi_q[i];
    end
  end

  pmon_ovf_stat u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (ovf_vec),
    .clr_vec  (clr_vec),
    .int_mask (int_mask),
    .status   (ovf_status),
    .irq      (irq)
  );

  pmon_rdmux #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W)) u_rd (
    .gp_vals (gp_vals),
    .fx_vals (fx_vals),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .rd_err  (rd_err)
  );
endmodule

// File: rtl/pmon_unit_chk.sv
module pmon_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] ovf_vec,
  input logic [63:0] clr_vec,
  input logic [63:0] status,
  input logic [63:0] int_mask,
  input logic        irq,
  input logic [31:0] rd_idx,
  input logic [63:0] rd_data,
  input logic        rd_err
);
  genvar b;
  generate
    for (b = 0; b < 64; b++) begin : g_bit
      // R5: a wrap sets the owning status bit on the same edge
      assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_vec[b] |=> status[b]);
      // R6: a covering clear with no concurrent wrap empties the bit
      assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[b] && !ovf_vec[b]) |=> !status[b]);
      // R6: a set bit stays set unless the clear mask covers it
      assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[b] && !clr_vec[b]) |=> status[b]);
      // R7: a wrap beats a clear on the same edge
      assert_ovf_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec[b] && clr_vec[b]) |=> status[b]);
    end
  endgenerate

  // R8: an enabled overflow raises the interrupt one edge later
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf_vec & int_mask)) |=> (irq || !$stable(int_mask)));

  // R8: the interrupt holds while nothing is cleared and enables are steady
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && clr_vec == 64'd0) |=> (irq || !$stable(int_mask)));

  // R8: the interrupt never stands without a pending status bit
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 64'd0));

  // R10: a narrow read has a zero upper half
  assert_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx[31] |-> (rd_data[63:32] == 32'd0));

  // R11: a bad index returns zero data
  assert_bad_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_data == 64'd0));
endmodule

bind pmon_unit pmon_unit_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ovf_vec  (ovf_vec),
  .clr_vec  (clr_vec),
  .status   (ovf_status),
  .int_mask (int_mask),
  .irq      (irq),
  .rd_idx   (rd_idx),
  .rd_data  (rd_data),
  .rd_err   (rd_err)
);

// File: tb/pmon_unit_tb.sv
module pmon_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NGP = 4;
  localparam int NFX = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_kind = '0;
  logic [4:0]     wr_idx = '0;
  logic [63:0]    wr_data = '0;
  logic [NGP-1:0] gp_evt = '0;
  logic [NGP-1:0] gp_int_en = '0;
  logic [NFX-1:0] fx_evt = '0;
  logic           user_mode = 1'b0;
  logic [31:0]    rd_idx = '0;
  logic [63:0]    rd_data, gbl_enable, ovf_status;
  logic           rd_err, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmon_unit #(.NUM_GP(NGP), .NUM_FX(NFX), .GP_W(48), .FX_W(48)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .gp_evt(gp_evt), .gp_int_en(gp_int_en), .fx_evt(fx_evt),
    .user_mode(user_mode), .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err),
    .gbl_enable(gbl_enable), .ovf_status(ovf_status), .irq(irq)
  );

  // 32-bit write value sign-extended to a 48-bit counter, computed arithmetically.
  function automatic logic [63:0] sx48(input logic [31:0] v);
    if (v >= 32'h8000_0000) return 64'(v) + (64'd1 << 48) - (64'd1 << 32);
    return 64'(v);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] k, input int i, input logic [63:0] d);
    wr_en = 1'b1; wr_kind = k; wr_idx = 5'(i); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rdchk(input string tag, input logic [31:0] idx,
                       input logic [63:0] exp_d, input logic exp_e);
    rd_idx = idx;
    #1;
    chk(tag, rd_data, exp_d);
    chk({tag, " err"}, 64'(rd_err), 64'(exp_e));
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [4];
    vals[0] = 32'h1234_5678; vals[1] = 32'h89AB_CDEF;
    vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h0000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < NGP; i++) rdchk("R1 gp reset", 32'(i), 64'd0, 1'b0);
    for (int i = 0; i < NFX; i++) rdchk("R1 fx reset", 32'h4000_0000 | 32'(i), 64'd0, 1'b0);
    chk("R1 status", ovf_status, 64'd0);
    chk("R1 enable", gbl_enable, 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);

    // R2, R9, R10: write sign extension and both read widths, both banks
    for (int v = 0; v < 4; v++) begin
      for (int i = 0; i < NGP; i++) begin
        wr(3'd0, i, {32'hA5A5_5A5A, vals[v]});
        rdchk("R2 R9 gp full", 32'(i), sx48(vals[v]), 1'b0);
        rdchk("R10 gp narrow", 32'h8000_0000 | 32'(i), 64'(vals[v]), 1'b0);
      end
      for (int i = 0; i < NFX; i++) begin
        wr(3'd1, i, {32'h5A5A_A5A5, vals[v]});
        rdchk("R2 R9 fx full", 32'h4000_0000 | 32'(i), sx48(vals[v]), 1'b0);
        rdchk("R10 fx narrow", 32'hC000_0000 | 32'(i), 64'(vals[v]), 1'b0);
      end
    end

    // R3: every general-purpose enable pattern
    for (int pat = 0; pat < 16; pat++) begin
      int n;
      n = pat % 3 + 1;
      for (int i = 0; i < NGP; i++) wr(3'd0, i, 64'd0);
      wr(3'd3, 0, 64'(pat));
      gp_evt = 4'b1111;
      repeat (n) tick();
      gp_evt = 4'b0101;
      tick();
      gp_evt = '0;
      for (int i = 0; i < NGP; i++) begin
        logic [63:0] e;
        e = pat[i] ? 64'(n + ((i % 2 == 0) ? 1 : 0)) : 64'd0;
        rdchk("R3 gp count", 32'(i), e, 1'b0);
      end
    end
    wr(3'd3, 0, 64'd0);

    // R4: fixed-counter mode fields, every counter, both modes
    for (int i = 0; i < NFX; i++) wr(3'd1, i, 64'd0);
    for (int f = 0; f < NFX; f++) begin
      for (int fld = 0; fld < 4; fld++) begin
        for (int um = 0; um < 2; um++) begin
          logic ok;
          for (int i = 0; i < NFX; i++) wr(3'd1, i, 64'd0);
          wr(3'd2, 0, 64'(fld) << (4 * f));
          wr(3'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
          user_mode = um[0];
          fx_evt = '1;
          repeat (3) tick();
          fx_evt = '0;
          ok = um ? fld[1] : fld[0];
          for (int i = 0; i < NFX; i++)
            rdchk("R4 fx mode count", 32'h4000_0000 | 32'(i),
                  (i == f && ok) ? 64'd3 : 64'd0, 1'b0);
        end
      end
    end
    // R4: field permits but global bit off
    wr(3'd1, 0, 64'd0);
    wr(3'd2, 0, 64'h3);
    wr(3'd3, 0, 64'hFFFF_FFFE_FFFF_FFFF);
    fx_evt = '1; repeat (2) tick(); fx_evt = '0;
    rdchk("R4 fx global off", 32'h4000_0000, 64'd0, 1'b0);
    chk("R4 enable unimplemented bits", gbl_enable, 64'h0000_0006_0000_000F);
    wr(3'd3, 0, 64'd0);
    wr(3'd2, 0, 64'd0);
    user_mode = 1'b0;

    // R5, R6, R8: overflow of each general-purpose counter
    gp_int_en = 4'b1010;
    for (int j = 0; j < NGP; j++) begin
      wr(3'd0, j, 64'hFFFF_FFFF);
      wr(3'd3, 0, 64'd1 << j);
      gp_evt[j] = 1'b1; tick(); gp_evt = '0;
      rdchk("R5 gp wrapped", 32'(j), 64'd0, 1'b0);
      chk("R5 gp status", ovf_status, 64'd1 << j);
      chk("R8 gp irq", 64'(irq), 64'(j % 2));
      repeat (3) tick();
      chk("R8 gp irq holds", 64'(irq), 64'(j % 2));
      wr(3'd4, 0, ~(64'd1 << j));
      chk("R6 uncovered bit kept", ovf_status, 64'd1 << j);
      wr(3'd4, 0, 64'd1 << j);
      chk("R6 covered bit cleared", ovf_status, 64'd0);
      chk("R8 irq drops", 64'(irq), 64'd0);
    end
    // R5, R6, R8: overflow of each fixed counter
    for (int f = 0; f < NFX; f++) begin
      wr(3'd2, 0, 64'((f % 2 == 1) ? 4'b1001 : 4'b0001) << (4 * f));
      wr(3'd3, 0, 64'd1 << (32 + f));
      wr(3'd1, f, 64'hFFFF_FFFF);
      fx_evt[f] = 1'b1; tick(); fx_evt = '0;
      rdchk("R5 fx wrapped", 32'h4000_0000 | 32'(f), 64'd0, 1'b0);
      chk("R5 fx status", ovf_status, 64'd1 << (32 + f));
      chk("R8 fx irq", 64'(irq), 64'(f % 2));
      wr(3'd4, 0, 64'd1 << (32 + f));
      chk("R6 fx cleared", ovf_status, 64'd0);
      chk("R8 fx irq drops", 64'(irq), 64'd0);
    end
    wr(3'd2, 0, 64'd0);

    // R6: partial clear of two pending bits
    wr(3'd0, 0, 64'hFFFF_FFFF);
    wr(3'd0, 1, 64'hFFFF_FFFF);
    wr(3'd3, 0, 64'h3);
    gp_evt = 4'b0011; tick(); gp_evt = '0;
    chk("R5 two bits", ovf_status, 64'h3);
    wr(3'd4, 0, 64'h1);
    chk("R6 partial clear", ovf_status, 64'h2);
    chk("R8 irq from gp1", 64'(irq), 64'd1);
    wr(3'd4, 0, 64'h2);

    // R7: overflow coincides with a covering clear
    wr(3'd0, 2, 64'hFFFF_FFFF);
    wr(3'd3, 0, 64'h4);
    gp_evt[2] = 1'b1;
    wr(3'd4, 0, 64'h4);
    gp_evt = '0;
    chk("R7 bit survives clear", ovf_status, 64'h4);
    wr(3'd4, 0, 64'h4);
    chk("R7 later clear works", ovf_status, 64'd0);

    // R12: write beats a same-cycle event
    wr(3'd0, 0, 64'd5);
    wr(3'd3, 0, 64'h1);
    gp_evt[0] = 1'b1;
    wr(3'd0, 0, 64'h100);
    rdchk("R12 write wins", 32'd0, 64'h100, 1'b0);
    tick();
    gp_evt = '0;
    rdchk("R12 counts after write", 32'd0, 64'h101, 1'b0);
    wr(3'd3, 0, 64'd0);

    // R11: indices naming no counter
    rdchk("R11 gp index 4", 32'd4, 64'd0, 1'b1);
    rdchk("R11 fx index 3", 32'h4000_0003, 64'd0, 1'b1);
    rdchk("R11 fx narrow index 7", 32'hC000_0007, 64'd0, 1'b1);
    rdchk("R11 gp index 100", 32'd100, 64'd0, 1'b1);
    rdchk("R11 valid index", 32'd0, 64'h101, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule